// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that gives each subroutine a fresh set of registers by sliding a window over a larger physical array. Every access uses a 5-bit architectural index. Indices 0 to 7 are globals shared by all windows. Indices 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. The current window pointer selects which physical slice the outs, locals and ins reach. The outs of window N are the same storage as the ins of window (N-1) mod NWIN, so arguments pass between caller and callee without copying.

A save request moves the pointer down by one and a restore request moves it up by one, both modulo NWIN. NWIN is a power of two between 2 and 32. An invalid-window mask has one bit per window, where 1 means invalid. A save or restore whose target window is marked invalid raises overflow or underflow in the same cycle. In that case the pointer stays where it is and any write issued in that cycle is dropped. A trap-entry request decrements the pointer without consulting the mask. A control port loads the pointer and the mask directly. There are two combinational read ports and one write port that takes effect on the clock edge.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, the invalid-window mask is all zeros, and both overflow and underflow are low.
- R2: Reading index 0 on either port returns zero, and a write to index 0 has no effect.
- R3: Indices 1 to 7 reach the same storage whatever the window pointer is.
- R4: Indices 16 to 23 are private to each window: a write in one window is not seen at the same index in another window.
- R5: Out index 8+k in window N and in index 24+k in window (N-1) mod NWIN (k = 0..7) are the same register. This includes the wrap from window 0 to window NWIN-1.
- R6: A save whose target window (pointer-1 mod NWIN) has mask bit 0 sets the pointer to that value at the next edge, so 0 goes to NWIN-1. A write issued in the same cycle lands in the window that was selected before the move.
- R7: A restore whose target window (pointer+1 mod NWIN) has mask bit 0 sets the pointer to that value at the next edge, so NWIN-1 goes to 0.
- R8: A save whose target mask bit is 1 drives overflow high in that cycle. The pointer is unchanged after the edge and a write issued in that cycle is discarded.
- R9: A restore whose target mask bit is 1 drives underflow high in that cycle, and the pointer is unchanged after the edge.
- R10: A trap-entry request decrements the pointer modulo NWIN even when the target mask bit is 1, and it raises no flag.
- R11: A control write of the pointer or of the mask takes effect at the next edge. A pointer write takes priority over trap, save and restore in the same cycle, and it suppresses their flags.
- R12: A read of the register being written in the same cycle returns the old value, and the new value appears after the edge.
- R13: When save and restore are requested together, only the save acts. Priority is pointer write, then trap, then save, then restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move window pointer down with mask check |
| restore_req | input | 1 | Move window pointer up with mask check |
| trap_req | input | 1 | Move window pointer down without mask check |
| ctl_cwp_we | input | 1 | Load window pointer |
| ctl_cwp_val | input | log2(NWIN) | Pointer value to load |
| ctl_wim_we | input | 1 | Load invalid-window mask |
| ctl_wim_val | input | NWIN | Mask value to load |
| cwp | output | log2(NWIN) | Current window pointer |
| wim | output | NWIN | Current invalid-window mask |
| ovf | output | 1 | Save targets an invalid window |
| unf | output | 1 | Restore targets an invalid window |

## Verification
A wrong slice mapping shows up only when a value written through one window is read through another. For that reason the tests write in one window, move the pointer, and read back in the next cycle. A pointer that moves when it should not is visible on `cwp` one edge after the faulting request, and the dropped write is visible on the read port right after that edge. A flag that asserts late would miss the request cycle entirely. The flags are therefore sampled in the same cycle as the request, before the edge.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CW = $clog2(NWIN),
  localparam int NPHYS = 16 * NWIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_req,
  input  logic            ctl_cwp_we,
  input  logic [CW-1:0]   ctl_cwp_val,
  input  logic            ctl_wim_we,
  input  logic [NWIN-1:0] ctl_wim_val,
  output logic [CW-1:0]   cwp,
  output logic [NWIN-1:0] wim,
  output logic            ovf,
  output logic            unf
);

  logic [XLEN-1:0] glb [0:7];
  logic [XLEN-1:0] win [NPHYS];
  logic [CW-1:0]   cwp_q, cwp_dn, cwp_up;
  logic [NWIN-1:0] wim_q;
  logic [CW+3:0]   pa, pb, pw;
  logic            wr_kill;

  function automatic logic [CW+3:0] slot(input logic [4:0] idx, input logic [CW-1:0] w);
    if (idx[4]) return {w, idx[3:0]};
    return {w - 1'b1, 1'b1, idx[2:0]};
  endfunction

  assign cwp_dn = cwp_q - 1'b1;
  assign cwp_up = cwp_q + 1'b1;

  assign ovf = save_req && !trap_req && !ctl_cwp_we && wim_q[cwp_dn];
  assign unf = restore_req && !save_req && !trap_req && !ctl_cwp_we && wim_q[cwp_up];
  assign wr_kill = ovf || unf;

  assign pa = slot(rd_a_idx, cwp_q);
  assign pb = slot(rd_b_idx, cwp_q);
  assign pw = slot(wr_idx, cwp_q);

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 :
                     (rd_a_idx[4:3] == 2'b00) ? glb[rd_a_idx[2:0]] : win[pa];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 :
                     (rd_b_idx[4:3] == 2'b00) ? glb[rd_b_idx[2:0]] : win[pb];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_kill && wr_idx != 5'd0) begin
      if (wr_idx[4:3] == 2'b00) glb[wr_idx[2:0]] <= wr_data;
      else win[pw] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      wim_q <= '0;
    end else begin
      if (ctl_cwp_we)                  cwp_q <= ctl_cwp_val;
      else if (trap_req)               cwp_q <= cwp_dn;
      else if (save_req && !ovf)       cwp_q <= cwp_dn;
      else if (restore_req && !save_req && !unf) cwp_q <= cwp_up;
      if (ctl_wim_we) wim_q <= ctl_wim_val;
    end
  end

  assign cwp = cwp_q;
  assign wim = wim_q;

endmodule

module win_regfile_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CW = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic            save_req,
  input logic            restore_req,
  input logic            trap_req,
  input logic            ctl_cwp_we,
  input logic            ctl_wim_we,
  input logic [NWIN-1:0] ctl_wim_val,
  input logic [CW-1:0]   cwp,
  input logic [NWIN-1:0] wim,
  input logic            ovf,
  input logic            unf
);

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);

  // R6
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !trap_req && !ctl_cwp_we && !ovf) |=> cwp == CW'($past(cwp) - 1'b1));

  // R7
  restore_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !trap_req && !ctl_cwp_we && !unf) |=> cwp == CW'($past(cwp) + 1'b1));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(cwp));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> $stable(cwp));

  // R10
  trap_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ctl_cwp_we) |=> cwp == CW'($past(cwp) - 1'b1));

  // R11
  wim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wim_we |=> wim == $past(ctl_wim_val));

  // R13
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (.*);

// File: tb/tb_win_regfile.sv
module tb_win_regfile;
  localparam int CLK_NS = 10;
  localparam int NWIN = 8;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0, trap_req = 0;
  logic ctl_cwp_we = 0, ctl_wim_we = 0;
  logic [2:0] ctl_cwp_val = 0, cwp;
  logic [NWIN-1:0] ctl_wim_val = 0, wim;
  logic ovf, unf;
  int checks = 0, errors = 0;
  bit done = 0;

  win_regfile #(.NWIN(NWIN), .XLEN(XLEN)) dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(logic [4:0] i, logic [XLEN-1:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rda(logic [4:0] i, output logic [XLEN-1:0] d);
    rd_a_idx = i; #1; d = rd_a_data;
  endtask

  task automatic set_cwp(logic [2:0] v);
    ctl_cwp_we = 1; ctl_cwp_val = v; tick(); ctl_cwp_we = 0;
  endtask

  task automatic set_wim(logic [NWIN-1:0] v);
    ctl_wim_we = 1; ctl_wim_val = v; tick(); ctl_wim_we = 0;
  endtask

  task automatic t_reset();
    chk("R1 cwp", 32'(cwp), 0);
    chk("R1 wim", 32'(wim), 0);
    chk("R1 flags", {30'd0, ovf, unf}, 0);
  endtask

  task automatic t_zero();
    logic [XLEN-1:0] d;
    wr(5'd0, 32'hDEAD_BEEF);
    rda(5'd0, d); chk("R2 port a", d, 0);
    rd_b_idx = 0; #1; chk("R2 port b", rd_b_data, 0);
  endtask

  task automatic t_globals();
    logic [XLEN-1:0] d;
    set_cwp(3'd2); wr(5'd3, 32'hA0A0_0003);
    set_cwp(3'd5); rda(5'd3, d); chk("R3", d, 32'hA0A0_0003);
  endtask

  task automatic t_locals();
    logic [XLEN-1:0] d;
    set_cwp(3'd1); wr(5'd17, 32'h1111);
    set_cwp(3'd4); wr(5'd17, 32'h4444);
    rda(5'd17, d); chk("R4 win4", d, 32'h4444);
    set_cwp(3'd1); rda(5'd17, d); chk("R4 win1", d, 32'h1111);
  endtask

  task automatic t_overlap();
    logic [XLEN-1:0] d;
    set_cwp(3'd3); wr(5'd10, 32'h0303_000A);
    set_cwp(3'd2); rda(5'd26, d); chk("R5", d, 32'h0303_000A);
    set_cwp(3'd0); wr(5'd15, 32'h0000_F00F);
    set_cwp(3'd7); rda(5'd31, d); chk("R5 wrap", d, 32'h0000_F00F);
  endtask

  task automatic t_save_restore();
    logic [XLEN-1:0] d;
    set_wim('0); set_cwp(3'd0);
    save_req = 1; tick(); save_req = 0;
    chk("R6 wrap", 32'(cwp), 7);
    save_req = 1; wr(5'd16, 32'h7777_0016); save_req = 0;
    chk("R6 move", 32'(cwp), 6);
    restore_req = 1; tick(); restore_req = 0;
    chk("R7 move", 32'(cwp), 7);
    rda(5'd16, d); chk("R6 write window", d, 32'h7777_0016);
    restore_req = 1; tick(); restore_req = 0;
    chk("R7 wrap", 32'(cwp), 0);
  endtask

  task automatic t_overflow();
    logic [XLEN-1:0] d;
    set_wim('0); set_cwp(3'd4); wr(5'd18, 32'h4040_0018);
    set_wim(8'b0000_1000);
    save_req = 1; wr_en = 1; wr_idx = 5'd18; wr_data = 32'hBAD0_0018; #1;
    chk("R8 flag", 32'(ovf), 1);
    tick(); save_req = 0; wr_en = 0;
    chk("R8 cwp", 32'(cwp), 4);
    rda(5'd18, d); chk("R8 write dropped", d, 32'h4040_0018);
  endtask

  task automatic t_underflow();
    set_wim(8'b0010_0000); set_cwp(3'd4);
    restore_req = 1; #1; chk("R9 flag", 32'(unf), 1);
    tick(); restore_req = 0;
    chk("R9 cwp", 32'(cwp), 4);
  endtask

  task automatic t_trap();
    set_wim(8'b0000_1000); set_cwp(3'd4);
    trap_req = 1; #1; chk("R10 no flag", {30'd0, ovf, unf}, 0);
    tick(); trap_req = 0;
    chk("R10 cwp", 32'(cwp), 3);
  endtask

  task automatic t_ctl();
    set_wim(8'b0000_1000); set_cwp(3'd4);
    chk("R11 wim load", 32'(wim), 32'h08);
    save_req = 1; ctl_cwp_we = 1; ctl_cwp_val = 3'd6; #1;
    chk("R11 flag masked", 32'(ovf), 0);
    tick(); save_req = 0; ctl_cwp_we = 0;
    chk("R11 cwp load", 32'(cwp), 6);
  endtask

  task automatic t_same_cycle();
    logic [XLEN-1:0] d;
    set_wim('0); set_cwp(3'd2); wr(5'd20, 32'h0000_0B0B);
    rd_a_idx = 5'd20; wr_en = 1; wr_idx = 5'd20; wr_data = 32'h0000_C0C0; #1;
    chk("R12 old", rd_a_data, 32'h0000_0B0B);
    tick(); wr_en = 0;
    rda(5'd20, d); chk("R12 new", d, 32'h0000_C0C0);
  endtask

  task automatic t_both();
    set_wim('0); set_cwp(3'd2);
    save_req = 1; restore_req = 1; tick(); save_req = 0; restore_req = 0;
    chk("R13", 32'(cwp), 1);
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    #1; t_reset();
    rst_n = 1; tick();
    t_reset();
    t_zero();
    t_globals();
    t_locals();
    t_overlap();
    t_save_restore();
    t_overflow();
    t_underflow();
    t_trap();
    t_ctl();
    t_same_cycle();
    t_both();
    finish_run();
  end
endmodule